// File: doc/BRIEF.md
# Contrast PWM Generator with Run-Time Count Source

This block drives the contrast control pin of an LCD panel with a pulse-width-modulated waveform. An 8-bit period counter advances on one of three event sources chosen at run time: the panel line-pulse strobe, the pixel-clock enable, or every cycle of the controller clock. The counter value is compared against a programmed pulse width, and the output is high while the count is below that width, so the duty cycle is `duty_val / 256`.

The pulse width is captured into a shadow register only at the wrap from 255 to 0, so a write in the middle of a period never produces a runt or stretched pulse. While contrast control is switched off, or while the reserved source code is selected, the output is held low, the counter sits at zero and the shadow follows the programmed width, so the first period after enabling already uses the current setting. All pins are plain levels or single-cycle strobes; no data stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `lcd_contrast_pwm`

## Requirements
- R1: While `rst_n` is low and after reset is released, `pwm_out` is low, the period counter is 0 and the width shadow is 0.
- R2: With `src_sel` = 2'b00 the counter advances by one on each cycle where `line_strobe` is high and holds otherwise.
- R3: With `src_sel` = 2'b01 the counter advances by one on each cycle where `pix_en` is high and holds otherwise.
- R4: With `src_sel` = 2'b10 the counter advances by one on every clock cycle, ignoring both strobes.
- R5: With `src_sel` = 2'b11 (reserved) `pwm_out` goes low and the counter is cleared, whatever the strobes and `ctl_on` do.
- R6: With `ctl_on` low `pwm_out` goes low, the counter is cleared and the shadow loads `duty_val` every cycle.
- R7: While enabled, `pwm_out` is high exactly when the counter is below the shadow width; a width of 0 keeps the output low for the whole period.
- R8: While enabled, a change of `duty_val` is taken into the shadow only on the source event that wraps the counter from 255 to 0.
- R9: The counter wraps from 255 to 0, so one PWM period lasts 256 source events; a width of 255 gives 255 high events out of 256.
- R10: `pwm_out` is a register: inputs sampled at clock edge k are reflected in `pwm_out` right after edge k and stay until edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse per panel line (source 2'b00) |
| pix_en | input | 1 | One-cycle pulse per pixel clock (source 2'b01) |
| ctl_on | input | 1 | Contrast control enable |
| src_sel | input | 2 | Count source: 00 line, 01 pixel, 10 every clock, 11 reserved |
| duty_val | input | 8 | Programmed pulse width |
| pwm_out | output | 1 | Contrast PWM output |

## Verification
Every result of this block is due one clock after the inputs that cause it: inputs sampled at an edge update the counter, the shadow and `pwm_out` at that same edge, so the effect is visible right after it. The bench drives inputs on the falling edge, pushes the expected output for the coming rising edge into a queue, and a monitor pops and compares one entry a short delay after each rising edge, so each expectation meets exactly the edge it belongs to. Mid-period width changes, wrap boundaries, zero and full widths, the reserved code and the off state are each run long enough to cover more than one full period.

// File: rtl/lcd_contrast_pwm_pkg.sv
package lcd_contrast_pwm_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    SRC_LINE  = 2'b00,
    SRC_PIXEL = 2'b01,
    SRC_CORE  = 2'b10,
    SRC_RSVD  = 2'b11
  } pwm_src_e;
endpackage

// File: rtl/pwm_event_select.sv
// Chooses the count event from the selected source and decides whether
// the generator is running at all.
module pwm_event_select
  import lcd_contrast_pwm_pkg::*;
(
  input  logic       line_strobe,
  input  logic       pix_en,
  input  logic       ctl_on,
  input  logic [1:0] src_sel,
  output logic       run,
  output logic       tick
);
  pwm_src_e src;
  assign src = pwm_src_e'(src_sel);

  always_comb begin
    unique case (src)
      SRC_LINE:  tick = line_strobe;
      SRC_PIXEL: tick = pix_en;
      SRC_CORE:  tick = 1'b1;
      default:   tick = 1'b0;
    endcase
  end

  assign run = ctl_on && (src != SRC_RSVD);
endmodule

// File: rtl/pwm_period_counter.sv
// Free-running period counter; cleared while stopped, wraps at the top.
module pwm_period_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap = run && tick && (cnt_q == TOP);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_width_compare.sv
// Holds the active width and produces the registered PWM level.
module pwm_width_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] duty_val,
  input  logic [W-1:0] cnt_d,
  output logic [W-1:0] shadow_q,
  output logic         pwm_out
);
  logic [W-1:0] shadow_d;
  logic         level_d;

  always_comb begin
    if (!run || wrap) shadow_d = duty_val;
    else              shadow_d = shadow_q;
  end

  // Compare on next-state values so the output lines up with the counter.
  assign level_d = run && (cnt_d < shadow_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pwm_out  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      pwm_out  <= level_d;
    end
  end
endmodule

// File: rtl/lcd_contrast_pwm.sv
module lcd_contrast_pwm
  import lcd_contrast_pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_strobe,
  input  logic         pix_en,
  input  logic         ctl_on,
  input  logic [1:0]   src_sel,
  input  logic [W-1:0] duty_val,
  output logic         pwm_out
);
  logic         run;
  logic         tick;
  logic         wrap;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] shadow_q;

  pwm_event_select u_sel (
    .line_strobe (line_strobe),
    .pix_en      (pix_en),
    .ctl_on      (ctl_on),
    .src_sel     (src_sel),
    .run         (run),
    .tick        (tick)
  );

  pwm_period_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d),
    .wrap  (wrap)
  );

  pwm_width_compare #(.W(W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wrap     (wrap),
    .duty_val (duty_val),
    .cnt_d    (cnt_d),
    .shadow_q (shadow_q),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/lcd_contrast_pwm_checker.sv
module lcd_contrast_pwm_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         line_strobe,
  input logic         pix_en,
  input logic         ctl_on,
  input logic [1:0]   src_sel,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] shadow_q,
  input logic         pwm_out
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!pwm_out && cnt_q == '0 && shadow_q == '0));

  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && src_sel == 2'b00 && !line_strobe) |=> $stable(cnt_q));

  p_pix_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && src_sel == 2'b01 && !pix_en) |=> $stable(cnt_q));

  p_core_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && src_sel == 2'b10) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  p_reserved_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11) |=> (!pwm_out && cnt_q == '0));

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_on |=> (!pwm_out && cnt_q == '0));

  p_high_below_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> (cnt_q < shadow_q));

  p_width_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && src_sel == 2'b10 && cnt_q != TOP) |=> $stable(shadow_q));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_on && src_sel == 2'b10 && cnt_q == TOP) |=> (cnt_q == '0));
endmodule

bind lcd_contrast_pwm lcd_contrast_pwm_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_strobe (line_strobe),
  .pix_en      (pix_en),
  .ctl_on      (ctl_on),
  .src_sel     (src_sel),
  .cnt_q       (cnt_q),
  .shadow_q    (shadow_q),
  .pwm_out     (pwm_out)
);

// File: tb/lcd_contrast_pwm_tb_top.sv
`timescale 1ns/1ps
module lcd_contrast_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_strobe = 1'b0;
  logic       pix_en = 1'b0;
  logic       ctl_on = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] duty_val = 8'd0;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  int m_cnt = 0;
  int m_sh  = 0;

  always #2 clk = ~clk;

  lcd_contrast_pwm dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_strobe (line_strobe),
    .pix_en      (pix_en),
    .ctl_on      (ctl_on),
    .src_sel     (src_sel),
    .duty_val    (duty_val),
    .pwm_out     (pwm_out)
  );

  // monitor: one expectation per rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (pwm_out !== e.exp) begin
        errors++;
        $display("FAIL %s: pwm_out=%0b expected %0b at %0t", e.tag, pwm_out, e.exp, $time);
      end
    end
  end

  task automatic step(input bit on, input bit [1:0] sel, input int duty,
                      input bit ln, input bit px, input string tag);
    bit act;
    bit tk;
    int ncnt;
    int nsh;
    @(negedge clk);
    ctl_on = on; src_sel = sel; duty_val = 8'(duty);
    line_strobe = ln; pix_en = px;
    act = on && (sel != 2'b11);
    tk  = (sel == 2'b00) ? ln : (sel == 2'b01) ? px : (sel == 2'b10);
    if (!act) begin
      ncnt = 0; nsh = duty;
    end else begin
      ncnt = tk ? ((m_cnt + 1) % 256) : m_cnt;
      nsh  = (tk && m_cnt == 255) ? duty : m_sh;
    end
    m_cnt = ncnt; m_sh = nsh;
    sb_q.push_back('{exp: act && (ncnt < nsh), tag: tag});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state at the output
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: pwm_out=%0b expected 0 during reset", pwm_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_sh = 0;

    // R1: stays low after reset with width shadow 0 even when counting
    for (int i = 0; i < 8; i++) step(1'b1, 2'b10, 100, 1'b0, 1'b0, "R1");
    // off to load width, then core clock count: R4 R10 R7
    step(1'b0, 2'b10, 64, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 600; i++) step(1'b1, 2'b10, 64, 1'b1, 1'b0, "R4 R10 R7");
    // R8: width changed mid-period only takes effect at wrap
    for (int i = 0; i < 600; i++) step(1'b1, 2'b10, (i < 300) ? 200 : 17, 1'b0, 1'b1, "R8");
    // R2: line pulse source, strobe every third cycle, pixel enable noise
    for (int i = 0; i < 1700; i++) step(1'b1, 2'b00, 40, (i % 3) == 0, (i % 2) == 0, "R2");
    // R3: pixel enable source, irregular pattern
    for (int i = 0; i < 1200; i++) step(1'b1, 2'b01, 90, (i % 5) == 0, ($urandom % 4) != 0, "R3");
    // R5: reserved source
    for (int i = 0; i < 30; i++) step(1'b1, 2'b11, 250, 1'b1, 1'b1, "R5");
    // R6: disabled
    for (int i = 0; i < 30; i++) step(1'b0, 2'b10, 250, 1'b1, 1'b1, "R6");
    // R7: zero width never high
    for (int i = 0; i < 600; i++) step(1'b1, 2'b10, 0, 1'b0, 1'b0, "R7");
    // R9: full width, wrap to 0
    step(1'b0, 2'b10, 255, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 800; i++) step(1'b1, 2'b10, 255, 1'b0, 1'b0, "R9");
    // R5 again after running, then resume
    for (int i = 0; i < 5; i++) step(1'b1, 2'b11, 128, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 300; i++) step(1'b1, 2'b10, 128, 1'b0, 1'b0, "R9 R7");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule